// File: doc/BRIEF.md
# Port Pull-Up Control Register

This block is a single memory-mapped control register. It selects the on-chip pull-up devices for four 8-bit I/O ports, named B, F, G and H. The same byte also holds a pending flag for a keyboard-style wired-OR interrupt on port H. Software reaches it through a simple synchronous bus port at one fixed address. Reads are combinational. Writes land on the next rising clock edge.

The per-port enable bits never drive the pull-ups directly. A global pull-up enable from the system configuration gates all four ports. Expanded operating mode turns off the ports B and F pull-ups, because those pins then carry bus or display traffic. An active serial-receiver-enable input turns off the pull-up on port G pin 0, which is the receive pin.

Port H pin levels pass through a synchronizer. A falling edge on any pin sets the interrupt flag while the port H pull-ups are active. The flag drives the interrupt request until software clears it by writing a one to the flag bit.

Top module: `pullup_ctl`

## Requirements
- R1: The register responds only at bus address 0x002C. A read at any other address returns 0x00, and a write at any other address changes nothing.
- R2: Read bits 7..5 are always zero.
- R3: After reset the register reads 0x0F. All four enables are set and the flag (bit 4) is clear.
- R4: A write with bit 4 = 1 clears the flag. A write with bit 4 = 0 leaves the flag unchanged.
- R5: When the global pull-up enable is low, all 32 pull-up outputs are 0. When it is high, each port's 8 outputs follow its enable bit, unless R6 or R7 applies.
- R6: In expanded mode the port F and port B pull-up outputs are 0, whatever their enable bits say.
- R7: While the serial receiver is enabled, port G pull-up bit 0 is 0, and port G bits 7..1 still follow the port G enable.
- R8: A falling edge on any port H pin sets the flag, provided the global enable and the port H enable (bit 3) are both 1. The flag becomes visible after the third rising edge following the pin change. With either enable off, the edge does nothing.
- R9: If a flag-setting edge and a clearing write fall in the same cycle, the flag ends up set.
- R10: The interrupt request output equals the flag and stays high until it is cleared.
- R11: A write at the register address loads bits 3..0 as the enables: bit 3 = port H, bit 2 = port G, bit 1 = port F, bit 0 = port B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when the register is not addressed |
| pu_global_en | input | 1 | Global pull-up enable from system configuration |
| expanded_mode | input | 1 | Expanded operating mode |
| rx2_en | input | 1 | Serial receiver enabled |
| port_h_pins | input | 8 | Port H pin levels (asynchronous) |
| pu_b | output | 8 | Port B pull-up enables |
| pu_f | output | 8 | Port F pull-up enables |
| pu_g | output | 8 | Port G pull-up enables |
| pu_h | output | 8 | Port H pull-up enables |
| kbd_irq | output | 1 | Port H keyboard interrupt request |

## Verification
Several behaviours are checked by the assertions on every cycle:
- The reserved read bits stay at zero.
- The global, expanded-mode and receiver overrides hold at the outputs.
- A clearing write with no competing edge empties the flag.
- A set edge always wins over a clear.
- The request holds until cleared.

Other behaviours can only be shown by the bench's scenarios: the exact three-edge latency from a pin change to the flag, the address decoding, the reset value, and the mapping from each enable bit to its port. The bench also shows that edges are ignored while the port H pull-ups are off.

// File: rtl/pu_pkg.sv
package pu_pkg;
   // Bits 4..0 of the register; bits 7..5 are reserved.
   typedef struct packed {
      logic flag;
      logic en_h;
      logic en_g;
      logic en_f;
      logic en_b;
   } pu_fields_t;

   localparam int FIELD_W = $bits(pu_fields_t);
   localparam pu_fields_t FIELDS_RESET = '{flag: 1'b0, en_h: 1'b1, en_g: 1'b1,
                                          en_f: 1'b1, en_b: 1'b1};
endpackage

// File: rtl/pu_sync_fall.sv
module pu_sync_fall #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic         arm,
   output logic         fall_any
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pu_sync_fall: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;
   logic [W-1:0]             last;
   logic [W-1:0]             synced;

   assign synced = stg[STAGES-1];

   // Idle level is high, so reset to ones to avoid a spurious edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= '1;
         last <= '1;
      end else begin
         stg  <= {stg[STAGES-2:0], pins};
         last <= synced;
      end
   end

   assign fall_any = arm & (|(last & ~synced));
endmodule

// File: rtl/pu_regfile.sv
module pu_regfile
   import pu_pkg::*;
#(
   parameter int          ADDR_W = 16,
   parameter int          DATA_W = 8,
   parameter logic [15:0] BASE   = 16'h002C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              set_evt,
   output pu_fields_t        fields
);
   generate
      if (DATA_W < FIELD_W) begin : g_bad_width
         $error("pu_regfile: DATA_W too small for the fields");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE);

   logic       hit, wr_hit, clr_req;
   pu_fields_t nxt;

   assign hit     = bus_sel && (bus_addr == MY_ADDR);
   assign wr_hit  = hit && bus_wr;
   assign clr_req = wr_hit && bus_wdata[FIELD_W-1];

   always_comb begin
      nxt = fields;
      if (wr_hit) begin
         nxt.en_h = bus_wdata[3];
         nxt.en_g = bus_wdata[2];
         nxt.en_f = bus_wdata[1];
         nxt.en_b = bus_wdata[0];
      end
      // A set edge wins over a clear in the same cycle.
      if (set_evt)      nxt.flag = 1'b1;
      else if (clr_req) nxt.flag = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fields <= FIELDS_RESET;
      else        fields <= nxt;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit && !bus_wr) bus_rdata[FIELD_W-1:0] = fields;
   end

   // R4: clearing write with no competing edge empties the flag
   p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_evt) |=> !fields.flag);
   // R9: set edge always leaves the flag set
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> fields.flag);
   // R10: flag holds until a clearing write
   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fields.flag && !clr_req) |=> fields.flag);
   // R2: reserved bits read zero
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:FIELD_W] == '0);
endmodule

// File: rtl/pu_gate.sv
module pu_gate #(
   parameter int W      = 8,
   parameter int RX_PIN = 0
) (
   input  logic         global_en,
   input  logic         expanded,
   input  logic         rx_en,
   input  logic         en_b,
   input  logic         en_f,
   input  logic         en_g,
   input  logic         en_h,
   output logic [W-1:0] pu_b,
   output logic [W-1:0] pu_f,
   output logic [W-1:0] pu_g,
   output logic [W-1:0] pu_h
);
   generate
      if (RX_PIN < 0 || RX_PIN >= W) begin : g_bad_rx
         $error("pu_gate: RX_PIN outside the port");
      end
   endgenerate

   logic bus_free;
   assign bus_free = global_en && !expanded;

   assign pu_b = {W{bus_free && en_b}};
   assign pu_f = {W{bus_free && en_f}};
   assign pu_h = {W{global_en && en_h}};

   for (genvar i = 0; i < W; i++) begin : g_gbit
      if (i == RX_PIN) begin : g_rx
         assign pu_g[i] = global_en && en_g && !rx_en;
      end else begin : g_plain
         assign pu_g[i] = global_en && en_g;
      end
   end

   // R5: global disable forces every output off
   always_comb begin
      if (!global_en)
         p_global_off_r5: assert ((pu_b | pu_f | pu_g | pu_h) == '0);
   end
   // R6: expanded mode forces ports B and F off
   always_comb begin
      if (expanded)
         p_expanded_off_r6: assert ((pu_b | pu_f) == '0);
   end
   // R7: receiver enable forces the receive pin off
   always_comb begin
      if (rx_en)
         p_rx_pin_off_r7: assert (!pu_g[RX_PIN]);
   end
endmodule

// File: rtl/pullup_ctl.sv
module pullup_ctl
   import pu_pkg::*;
#(
   parameter int          PORT_W      = 8,
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 8,
   parameter logic [15:0] REG_ADDR    = 16'h002C,
   parameter int          SYNC_STAGES = 2,
   parameter int          RX_PIN      = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pu_global_en,
   input  logic              expanded_mode,
   input  logic              rx2_en,
   input  logic [PORT_W-1:0] port_h_pins,
   output logic [PORT_W-1:0] pu_b,
   output logic [PORT_W-1:0] pu_f,
   output logic [PORT_W-1:0] pu_g,
   output logic [PORT_W-1:0] pu_h,
   output logic              kbd_irq
);
   pu_fields_t fields;
   logic       set_evt;
   logic       h_armed;

   assign h_armed = pu_global_en && fields.en_h;

   pu_sync_fall #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins     (port_h_pins),
      .arm      (h_armed),
      .fall_any (set_evt)
   );

   pu_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(REG_ADDR)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .set_evt   (set_evt),
      .fields    (fields)
   );

   pu_gate #(.W(PORT_W), .RX_PIN(RX_PIN)) u_gate (
      .global_en (pu_global_en),
      .expanded  (expanded_mode),
      .rx_en     (rx2_en),
      .en_b      (fields.en_b),
      .en_f      (fields.en_f),
      .en_g      (fields.en_g),
      .en_h      (fields.en_h),
      .pu_b      (pu_b),
      .pu_f      (pu_f),
      .pu_g      (pu_g),
      .pu_h      (pu_h)
   );

   assign kbd_irq = fields.flag;

   // R8: with port H pull-ups inactive the flag cannot rise
   p_no_set_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!h_armed && !kbd_irq) |=> !kbd_irq);
endmodule

// File: tb/tb_pullup_ctl.sv
module tb_pullup_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic       pu_global_en = 1'b1, expanded_mode = 1'b0, rx2_en = 1'b0;
   logic [7:0] port_h_pins = 8'hFF;
   logic [7:0] pu_b, pu_f, pu_g, pu_h;
   logic       kbd_irq;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   pullup_ctl dut (.*);

   localparam logic [15:0] A = 16'h002C;
   // glob exp rx | en HGFB | exp b f gHi g0 h
   localparam logic [11:0] VEC [8] = '{
      12'b100_1111_11111, 12'b000_1111_00000, 12'b110_1111_00111,
      12'b101_1111_11101, 12'b100_0101_10110, 12'b100_1010_01001,
      12'b111_1010_00001, 12'b011_0101_00000 };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      idle(3);
      rst_n = 1;
      // R3 reset state
      rd(A, d);
      chk("R3 reset value", d, 8'h0F);
      chk("R10 irq after reset", kbd_irq, 0);
      // R1 other address
      rd(16'h002D, d);
      chk("R1 read elsewhere", d, 0);
      wr(16'h002B, 8'h00);
      rd(A, d);
      chk("R1 write elsewhere ignored", d, 8'h0F);
      // R2 reserved bits
      wr(A, 8'hE5);
      rd(A, d);
      chk("R2 reserved read zero / R11 enables", d, 8'h05);

      // table walk: R5 R6 R7 R11
      for (int v = 0; v < 8; v++) begin
         logic [11:0] e;
         e = VEC[v];
         pu_global_en = e[11]; expanded_mode = e[10]; rx2_en = e[9];
         wr(A, {4'b0, e[8:5]});
         rd(A, d);
         chk("R11 enable readback", d, {4'b0, e[8:5]});
         chk("R5/R6 port B", pu_b, {8{e[4]}});
         chk("R5/R6 port F", pu_f, {8{e[3]}});
         chk("R5/R7 port G", pu_g, {{7{e[2]}}, e[1]});
         chk("R5 port H", pu_h, {8{e[0]}});
      end
      pu_global_en = 1; expanded_mode = 0; rx2_en = 0;
      wr(A, 8'h0F);

      // R8 edge latency
      @(negedge clk); port_h_pins = 8'hDF;
      idle(2);
      chk("R8 flag not yet after two edges", kbd_irq, 0);
      idle(1);
      chk("R8 flag set after third edge", kbd_irq, 1);
      // R10 hold, R4 write with bit4=0
      port_h_pins = 8'hFF;
      idle(6);
      chk("R10 irq holds", kbd_irq, 1);
      wr(A, 8'h0F);
      rd(A, d);
      chk("R4 zero write keeps flag", d, 8'h1F);
      wr(A, 8'h1F);
      rd(A, d);
      chk("R4 one write clears flag", d, 8'h0F);
      chk("R10 irq follows clear", kbd_irq, 0);

      // R8 no set with port H enable off
      wr(A, 8'h07);
      @(negedge clk); port_h_pins = 8'hFE;
      idle(5);
      chk("R8 no set when H disabled", kbd_irq, 0);
      port_h_pins = 8'hFF;
      idle(4);
      // R8 no set with global off
      wr(A, 8'h0F);
      pu_global_en = 0;
      @(negedge clk); port_h_pins = 8'h7F;
      idle(5);
      chk("R8 no set when global off", kbd_irq, 0);
      port_h_pins = 8'hFF;
      idle(4);
      pu_global_en = 1;
      idle(2);

      // R9 set and clear in the same cycle
      @(negedge clk); port_h_pins = 8'hF7;
      idle(2);
      bus_sel = 1; bus_wr = 1; bus_addr = A; bus_wdata = 8'h1F;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      chk("R9 set wins over clear", kbd_irq, 1);
      port_h_pins = 8'hFF;
      wr(A, 8'h1F);
      chk("R4 clear after collision", kbd_irq, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule